// File: doc/BRIEF.md
# Oversampling Bit Clock Recovery

This block rebuilds a receive bit clock from a serial NRZ or NRZI line that carries no clock of its own. A reference tick enable arrives at sixteen times the nominal bit rate, and a 4-bit phase counter splits every bit into sixteen steps. Count 0 is where a data transition is expected. Count 8 is where the bit is sampled. The recovered bit clock strobe fires whenever the counter returns to a lower value.

Each transition on the synchronized line is located in this phase window. A transition just after the expected point means the local clock runs ahead, so the bit is stretched by one step. A transition just before it means the clock lags, so the bit is shortened by one step. A transition near the middle of the window means the clock sits half a bit away from the data. The counter then jumps straight to 0 and an extra sample is taken, so a single transition is enough to lock. Transitions that come too close together are treated as interference and do not steer the phase.

An input turns the half-bit jump off and widens the stretch and shorten zones to cover the whole bit except the sample point. Another input says whether the line encoding is NRZ/NRZI; only then may the jump happen. All state moves only on reference ticks, except the input synchronizer, which runs on every system clock.

Top module: `bit_clock_recovery`

## Requirements
- R1: An active-low synchronous reset (rstN=0) clears the phase counter to 0, marks the interference timer idle, and drives bitClk, sampleStrobe and sampleBit to 0.
- R2: With no accepted transition, the phase counter steps 0..15 on successive ticks. bitClk pulses on the tick that takes the counter from 15 back to 0, so it is the 16th tick after reset.
- R3: sampleStrobe pulses on every tick taken at count 8. It also pulses on every half-bit jump. With each pulse, sampleBit takes the synchronized line level seen at that tick. sampleBit holds its value between pulses.
- R4: With shift enabled (shiftDisable=0), an accepted transition seen at count 1, 2 or 3 holds the counter for that tick. This lengthens the bit by one step.
- R5: With shift enabled, an accepted transition seen at count 13, 14 or 15 advances the counter by two. This shortens the bit by one step. A step past 15 wraps and pulses bitClk.
- R6: With shift enabled and nrzMode=1, an accepted transition seen at counts 6 to 10 reloads the counter to 0. On the same tick it pulses both sampleStrobe and bitClk.
- R7: With nrzMode=0, a transition seen at counts 6 to 10 leaves the phase untouched.
- R8: With shift enabled, a transition seen at count 0, 4, 5, 11 or 12 leaves the phase untouched.
- R9: With shiftDisable=1 there is never a jump. An accepted transition at counts 1 to 7 holds the counter, one at counts 9 to 15 advances it by two, and one at count 8 or 0 has no effect.
- R10: A transition is accepted only if no other transition was seen in the 15 ticks before it. A rejected transition still restarts that 15-tick window.
- R11: With refTick low, the counter does not move and bitClk and sampleStrobe stay 0. A line change made while ticks are absent is seen at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| refTick | input | 1 | Reference enable, one clk wide, 16 per nominal bit |
| serialIn | input | 1 | Asynchronous received data line |
| nrzMode | input | 1 | 1: NRZ/NRZI encoding selected, half-bit jump allowed |
| shiftDisable | input | 1 | 1: jump off, widened stretch/shorten zones |
| bitClk | output | 1 | One-clk strobe at each recovered bit boundary |
| sampleStrobe | output | 1 | One-clk strobe when sampleBit is refreshed |
| sampleBit | output | 1 | Most recently sampled data bit |

## Verification
A level put on serialIn needs two system clock edges to cross the synchronizer. The bench therefore changes the line two clocks before it raises a tick. bitClk, sampleStrobe and a new sampleBit all appear right after the clock edge that takes the tick. The bench makes its comparison at the falling edge that follows, and on every other falling edge it checks that both strobes are low. The expected result of each tick is computed by a phase model driven by the same line levels, then queued in tick order and compared in that order. A line change made while ticks are paused only counts at the next tick.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  // Phase steering command from the window logic, applied on a reference tick.
  typedef struct packed {
    logic hold;   // keep the counter: bit lengthened by one step
    logic skip;   // advance by two: bit shortened by one step
    logic jump;   // half-bit jump: reload to 0 with an extra sample
  } phaseCmd_t;

endpackage

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int STEPS       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refTick,
  input  logic          serialIn,
  input  phaseCmd_t     phaseCmd,
  output logic [CW-1:0] phaseCnt,
  output logic          edgeSeen,
  output logic          bitClk,
  output logic          sampleStrobe,
  output logic          sampleBit
);

  localparam logic [CW-1:0] SAMPLE_AT = CW'(STEPS / 2);
  localparam logic [CW-1:0] ONE_STEP  = CW'(1);
  localparam logic [CW-1:0] TWO_STEPS = CW'(2);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineNow;
  logic                   lastLine;
  logic [CW-1:0]          nextCnt;

  // Input synchronizer; its depth is a parameter.
  generate
    if (SYNC_STAGES == 1) begin : g_syncSingle
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= serialIn;
      end
    end else begin : g_syncChain
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], serialIn};
      end
    end
  endgenerate

  assign lineNow  = syncChain[SYNC_STAGES-1];

  // A transition is the line level differing from the level at the previous tick.
  assign edgeSeen = refTick && (lineNow != lastLine);

  // Counter step chosen by the command (the counter width is a power of two, so it wraps).
  always_comb begin
    if (phaseCmd.jump)      nextCnt = '0;
    else if (phaseCmd.hold) nextCnt = phaseCnt;
    else if (phaseCmd.skip) nextCnt = phaseCnt + TWO_STEPS;
    else                    nextCnt = phaseCnt + ONE_STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt     <= '0;
      lastLine     <= 1'b0;
      bitClk       <= 1'b0;
      sampleStrobe <= 1'b0;
      sampleBit    <= 1'b0;
    end else begin
      bitClk       <= 1'b0;
      sampleStrobe <= 1'b0;
      if (refTick) begin
        phaseCnt <= nextCnt;
        lastLine <= lineNow;
        bitClk   <= (nextCnt < phaseCnt);
        if ((phaseCnt == SAMPLE_AT) || phaseCmd.jump) begin
          sampleStrobe <= 1'b1;
          sampleBit    <= lineNow;
        end
      end
    end
  end

endmodule

// File: rtl/dpll_control.sv
module dpll_control
  import dpll_pkg::*;
#(
  parameter int STEPS      = 16,
  parameter int ADJ_SPAN   = 3,
  parameter int SHIFT_SPAN = 2,
  localparam int CW        = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refTick,
  input  logic          edgeSeen,
  input  logic [CW-1:0] phaseCnt,
  input  logic          nrzMode,
  input  logic          shiftDisable,
  output phaseCmd_t     phaseCmd
);

  localparam int            HALF       = STEPS / 2;
  localparam logic [CW-1:0] LATE_HI    = CW'(ADJ_SPAN);
  localparam logic [CW-1:0] EARLY_LO   = CW'(STEPS - ADJ_SPAN);
  localparam logic [CW-1:0] SHIFT_LO   = CW'(HALF - SHIFT_SPAN);
  localparam logic [CW-1:0] SHIFT_HI   = CW'(HALF + SHIFT_SPAN);
  localparam logic [CW-1:0] MID        = CW'(HALF);
  localparam logic [CW-1:0] GUARD_LOAD = CW'(STEPS - 1);

  logic [CW-1:0] guardCnt;
  logic          quiet;
  logic          accept;
  logic          inLate, inEarly, inShift, wideLate, wideEarly;

  // Interference guard: any transition reloads it; only a quiet guard accepts.
  assign quiet  = (guardCnt == '0);
  assign accept = edgeSeen && quiet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      guardCnt <= '0;
    end else if (refTick) begin
      if (edgeSeen)    guardCnt <= GUARD_LOAD;
      else if (!quiet) guardCnt <= guardCnt - CW'(1);
    end
  end

  // Window zones for the counter value at this tick.
  assign inLate    = (phaseCnt != '0) && (phaseCnt <= LATE_HI);
  assign inEarly   = (phaseCnt >= EARLY_LO);
  assign inShift   = (phaseCnt >= SHIFT_LO) && (phaseCnt <= SHIFT_HI);
  assign wideLate  = (phaseCnt != '0) && (phaseCnt < MID);
  assign wideEarly = (phaseCnt > MID);

  always_comb begin
    phaseCmd = '0;
    if (accept) begin
      if (shiftDisable) begin
        if (wideLate)       phaseCmd.hold = 1'b1;
        else if (wideEarly) phaseCmd.skip = 1'b1;
      end else begin
        if (inLate)                  phaseCmd.hold = 1'b1;
        else if (inEarly)            phaseCmd.skip = 1'b1;
        else if (inShift && nrzMode) phaseCmd.jump = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bit_clock_recovery.sv
module bit_clock_recovery
  import dpll_pkg::*;
#(
  parameter int STEPS       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADJ_SPAN    = 3,
  parameter int SHIFT_SPAN  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refTick,
  input  logic serialIn,
  input  logic nrzMode,
  input  logic shiftDisable,
  output logic bitClk,
  output logic sampleStrobe,
  output logic sampleBit
);

  localparam int CW = $clog2(STEPS);

  logic [CW-1:0] phaseCnt;
  logic          edgeSeen;
  phaseCmd_t     phaseCmd;

  dpll_datapath #(
    .STEPS      (STEPS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .refTick     (refTick),
    .serialIn    (serialIn),
    .phaseCmd    (phaseCmd),
    .phaseCnt    (phaseCnt),
    .edgeSeen    (edgeSeen),
    .bitClk      (bitClk),
    .sampleStrobe(sampleStrobe),
    .sampleBit   (sampleBit)
  );

  dpll_control #(
    .STEPS     (STEPS),
    .ADJ_SPAN  (ADJ_SPAN),
    .SHIFT_SPAN(SHIFT_SPAN)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .refTick     (refTick),
    .edgeSeen    (edgeSeen),
    .phaseCnt    (phaseCnt),
    .nrzMode     (nrzMode),
    .shiftDisable(shiftDisable),
    .phaseCmd    (phaseCmd)
  );

endmodule

// File: rtl/bit_clock_recovery_checker.sv
module bit_clock_recovery_checker
  import dpll_pkg::*;
#(
  parameter int STEPS = 16,
  localparam int CW   = $clog2(STEPS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          refTick,
  input logic          nrzMode,
  input logic          shiftDisable,
  input logic          bitClk,
  input logic          sampleStrobe,
  input logic          sampleBit,
  input logic [CW-1:0] phaseCnt,
  input phaseCmd_t     phaseCmd
);

  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  assert_pulse_needs_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    (bitClk || sampleStrobe) |-> $past(refTick));

  assert_cnt_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    !refTick |=> $stable(phaseCnt));

  assert_wrap_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (refTick && phaseCnt == LAST && phaseCmd == '0) |=> bitClk);

  assert_sample_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |-> $stable(sampleBit));

  assert_late_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (refTick && phaseCmd.hold) |=> $stable(phaseCnt));

  assert_jump_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (refTick && phaseCmd.jump) |=> (phaseCnt == '0 && sampleStrobe && bitClk));

  assert_no_jump_other_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    !nrzMode |-> !phaseCmd.jump);

  assert_single_cmd_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phaseCmd));

  assert_no_jump_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    shiftDisable |-> !phaseCmd.jump);

endmodule

bind bit_clock_recovery bit_clock_recovery_checker #(.STEPS(STEPS)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .refTick     (refTick),
  .nrzMode     (nrzMode),
  .shiftDisable(shiftDisable),
  .bitClk      (bitClk),
  .sampleStrobe(sampleStrobe),
  .sampleBit   (sampleBit),
  .phaseCnt    (phaseCnt),
  .phaseCmd    (phaseCmd)
);

// File: tb/tb_bit_clock_recovery.sv
module tb_bit_clock_recovery;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic serialIn = 1'b0;
  logic nrzMode = 1'b1;
  logic shiftDisable = 1'b0;
  logic bitClk, sampleStrobe, sampleBit;

  always #5 clk = ~clk;

  bit_clock_recovery dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .serialIn(serialIn),
    .nrzMode(nrzMode), .shiftDisable(shiftDisable),
    .bitClk(bitClk), .sampleStrobe(sampleStrobe), .sampleBit(sampleBit)
  );

  typedef struct {
    bit    clkP;
    bit    smp;
    bit    dat;
    string req;
  } exp_t;

  exp_t  expQ[$];
  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string curReq = "R2";

  // Phase model built from the requirements, in plain integers.
  int mPhase, mSince;
  bit mLevel, mNrz, mShiftDis;

  task automatic modelTick(input bit lvl, output exp_t e);
    int c, nxt;
    bit jmp, trans;
    c = mPhase;
    nxt = (c + 1) % 16;
    jmp = 0;
    mSince = (mSince < 16) ? mSince + 1 : 16;
    trans = (lvl != mLevel);
    mLevel = lvl;
    if (trans && mSince >= 16) begin
      if (mShiftDis) begin
        if (c >= 1 && c <= 7) nxt = c;
        else if (c >= 9) nxt = (c + 2) % 16;
      end else begin
        if (c >= 1 && c <= 3) nxt = c;
        else if (c >= 13) nxt = (c + 2) % 16;
        else if (mNrz && c >= 6 && c <= 10) begin nxt = 0; jmp = 1; end
      end
    end
    if (trans) mSince = 0;
    e.clkP = (nxt < c);
    e.smp  = (c == 8) || jmp;
    e.dat  = lvl;
    e.req  = curReq;
    mPhase = nxt;
  endtask

  // Monitor: compares every tick result against the queue, and checks that both strobes stay low between ticks.
  logic pendingCheck = 1'b0;
  always @(posedge clk) pendingCheck <= refTick;

  always @(negedge clk) begin
    exp_t e;
    if (!finished) begin
      if (pendingCheck) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R2: tick result with empty queue, actual bitClk=%0b expected a queued item", bitClk);
        end else begin
          e = expQ.pop_front();
          if (bitClk !== e.clkP || sampleStrobe !== e.smp || (e.smp && sampleBit !== e.dat)) begin
            fails++;
            $display("FAIL %s: actual bitClk=%0b sampleStrobe=%0b sampleBit=%0b, expected %0b %0b %0b",
                     e.req, bitClk, sampleStrobe, sampleBit, e.clkP, e.smp, e.dat);
          end
        end
      end else if (rstN) begin
        checks++;
        if (bitClk !== 1'b0 || sampleStrobe !== 1'b0) begin
          fails++;
          $display("FAIL R11: strobe without tick, actual bitClk=%0b sampleStrobe=%0b, expected 0 0",
                   bitClk, sampleStrobe);
        end
      end
    end
  end

  task automatic doReset(input bit nrz, input bit sdis);
    rstN = 1'b0;
    refTick = 1'b0;
    serialIn = 1'b0;
    nrzMode = nrz;
    shiftDisable = sdis;
    repeat (4) @(negedge clk);
    mPhase = 0; mSince = 16; mLevel = 0; mNrz = nrz; mShiftDis = sdis;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doTick(input bit lvl);
    exp_t e;
    @(negedge clk) serialIn = lvl;
    @(negedge clk);
    @(negedge clk);
    modelTick(lvl, e);
    expQ.push_back(e);
    refTick = 1'b1;
    @(negedge clk) refTick = 1'b0;
  endtask

  task automatic runTicks(input int n);
    repeat (n) doTick(mLevel);
  endtask

  // Places a transition that is accepted, at the given counter value.
  task automatic edgeAtPhase(input int target);
    while (!(mPhase == target && mSince >= 15)) doTick(mLevel);
    doTick(!mLevel);
  endtask

  task automatic randomStream(input int nBits);
    repeat (nBits) begin
      int hold;
      bit lvl;
      hold = 14 + $urandom_range(4);
      lvl = bit'($urandom_range(1));
      repeat (hold) doTick(lvl);
    end
  endtask

  task automatic checkDirect(input string req, input bit cond, input int act, input int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2: watchdog expired, actual 200000 cycles expected fewer");
    summary();
  end

  initial begin
    // R1: reset state, then a free run counted from reset
    doReset(1, 0);
    checkDirect("R1 bitClk", bitClk === 1'b0, bitClk, 0);
    checkDirect("R1 sampleStrobe", sampleStrobe === 1'b0, sampleStrobe, 0);
    checkDirect("R1 sampleBit", sampleBit === 1'b0, sampleBit, 0);
    curReq = "R1"; runTicks(16);
    curReq = "R2"; runTicks(24);

    // R1 again: reset in mid bit restarts the counter
    doReset(1, 0);
    curReq = "R1"; runTicks(17);

    // R6: one transition in the half-bit zone locks; R3 sampled data afterwards
    doReset(1, 0);
    curReq = "R6"; edgeAtPhase(7);
    curReq = "R3";
    runTicks(15); repeat (16) doTick(0); repeat (16) doTick(1);
    repeat (16) doTick(1); repeat (16) doTick(0);
    doReset(1, 0);
    curReq = "R6"; edgeAtPhase(10); edgeAtPhase(6); runTicks(20);

    // R4: late transitions stretch the bit
    doReset(1, 0);
    curReq = "R4"; edgeAtPhase(2); edgeAtPhase(1); edgeAtPhase(3); runTicks(20);

    // R5: early transitions shorten the bit, including the wrap from 15
    doReset(1, 0);
    curReq = "R5"; edgeAtPhase(14); edgeAtPhase(13); edgeAtPhase(15); runTicks(20);

    // R8: ignored zones
    doReset(1, 0);
    curReq = "R8"; edgeAtPhase(4); edgeAtPhase(5); edgeAtPhase(11);
    edgeAtPhase(12); edgeAtPhase(0); runTicks(20);

    // R7: other encoding, the half-bit zone takes no action
    doReset(0, 0);
    curReq = "R7"; edgeAtPhase(8); edgeAtPhase(6); edgeAtPhase(10); edgeAtPhase(2); runTicks(20);

    // R9: shift disabled, widened zones
    doReset(1, 1);
    curReq = "R9"; edgeAtPhase(5); edgeAtPhase(10); edgeAtPhase(8);
    edgeAtPhase(7); edgeAtPhase(9); edgeAtPhase(1); edgeAtPhase(15); runTicks(20);

    // R10: transitions too close together are rejected
    doReset(1, 0);
    curReq = "R10"; edgeAtPhase(2);
    runTicks(4); doTick(!mLevel);
    runTicks(14); doTick(!mLevel);
    runTicks(15); doTick(!mLevel);
    runTicks(20);

    // R11: no ticks, no movement; the line change counts at the next tick
    doReset(1, 0);
    curReq = "R11"; runTicks(5);
    repeat (12) @(negedge clk) serialIn = ~serialIn;
    @(negedge clk) serialIn = 1'b1;
    repeat (20) @(negedge clk);
    doTick(1); runTicks(30);

    // R3: jittered random data under both shift settings
    doReset(1, 0);
    curReq = "R3"; randomStream(40);
    doReset(1, 1);
    curReq = "R3"; randomStream(40);

    repeat (3) @(negedge clk);
    checkDirect("R2 queue drained", expQ.size() == 0, expQ.size(), 0);
    summary();
  end

endmodule